// File: doc/BRIEF.md
# SDRAM Bank State Protocol Checker

This is a passive monitor for the command bus of a four-bank synchronous DRAM. On every rising clock edge it decodes chip select, the three strobes, the bank select, the auto-precharge bit and the row address. From these it keeps a model of each bank: either idle, or open on a specific row. It drives no signal onto the memory bus. It reports each command that breaks the bank protocol as a one-cycle error pulse with a violation code.

Burst length is a configuration input given in beats. It lets the checker close a bank at the right cycle when a read or write requested automatic precharge. A refresh recovery window of `TRC_CYC` cycles follows every accepted auto refresh. During that window only NOP or an inhibited bus is allowed. Violating commands are reported but never applied, so the bank model always reflects legal traffic only.

Top module: `sdram_bank_monitor`

## Requirements
- R1: The bus decodes as follows. cs_n high is an inhibit. With cs_n low, {ras_n,cas_n,we_n} = 111 is NOP, 000 load mode, 001 auto refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop. Inhibit and NOP never raise an error and never change any bank.
- R2: An activate to an idle bank makes that bank's bit of bank_open go high on the edge that samples the command. From then on, that bank's slice of open_row holds the row address. Other banks are unchanged.
- R3: An activate to a bank that is already open reports code 2. The stored row is kept.
- R4: A read or write to an idle bank reports code 1.
- R5: A precharge with a10 low closes only the bank chosen by ba. A precharge with a10 high closes every bank whatever ba holds.
- R6: A read or write with a10 high sampled at edge t keeps its bank open through edge t+L-1 and closes it at edge t+L, where L is burst_len (0 counts as 1). With a10 low the bank stays open.
- R7: A load mode command while any bank is open reports code 3. With all banks idle it is legal.
- R8: An auto refresh while any bank is open reports code 4.
- R9: After an accepted auto refresh at edge t, any command other than NOP or inhibit at edges t+1 to t+TRC_CYC-1 reports code 5. From edge t+TRC_CYC on, commands are legal again.
- R10: A flagged command changes no bank state and does not start a refresh window. The error is a single-cycle err_valid pulse that appears after the edge sampling the command. Code 5 takes priority over all other codes.
- R11: After reset all banks are idle and err_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| row_addr | input | 13 | Row address for activate |
| burst_len | input | 4 | Burst length in beats (0 treated as 1) |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| open_row | output | 52 | Open row of bank b at bits [b*13 +: 13] |
| err_valid | output | 1 | One-cycle pulse on a violation |
| err_code | output | 3 | Violation code, valid with err_valid |

## Verification
A bank model that has drifted shows up in the next cycle. A wrong open bit or stored row is visible directly on bank_open and open_row. It also shows indirectly, because a following legal activate or read is then reported with code 2 or 1. An auto-precharge counter that is off by one moves the falling edge of bank_open by a cycle, so the bench samples the flag at each edge of the burst. A refresh window of the wrong length is caught by commands placed at its last busy cycle and at its first free cycle.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT = 4'd0,
        CMD_NOP     = 4'd1,
        CMD_MODE    = 4'd2,
        CMD_REFRESH = 4'd3,
        CMD_PRECHG  = 4'd4,
        CMD_ACTIVE  = 4'd5,
        CMD_WRITE   = 4'd6,
        CMD_READ    = 4'd7,
        CMD_BSTOP   = 4'd8
    } sbm_cmd_e;

    typedef enum logic [2:0] {
        VIO_NONE        = 3'd0,
        VIO_ACCESS_IDLE = 3'd1,
        VIO_ACT_OPEN    = 3'd2,
        VIO_MODE_OPEN   = 3'd3,
        VIO_REF_OPEN    = 3'd4,
        VIO_REF_WINDOW  = 3'd5
    } sbm_vio_e;

endpackage

// File: rtl/sbm_cmd_decode.sv
module sbm_cmd_decode
    import sbm_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sbm_cmd_e cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = CMD_INHIBIT;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MODE;
                3'b001:  cmd = CMD_REFRESH;
                3'b010:  cmd = CMD_PRECHG;
                3'b011:  cmd = CMD_ACTIVE;
                3'b100:  cmd = CMD_WRITE;
                3'b101:  cmd = CMD_READ;
                3'b110:  cmd = CMD_BSTOP;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sbm_refresh_timer.sv
module sbm_refresh_timer #(
    parameter int TRC_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(TRC_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(TRC_CYC - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] left;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.left = LOAD;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.left != '0);

    AST_WINDOW_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && TRC_CYC > 1) |=> busy); // R9
endmodule

// File: rtl/sbm_bank_tracker.sv
module sbm_bank_tracker #(
    parameter int ROW_W = 13,
    parameter int BL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic             do_rw,
    input  logic             auto_pre,
    input  logic [ROW_W-1:0] row_in,
    input  logic [BL_W-1:0]  burst_len,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);
    localparam logic [BL_W-1:0] ONE = BL_W'(1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic             pend;
        logic [BL_W-1:0]  cnt;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (do_pre) begin
            st_d.open = 1'b0;
            st_d.pend = 1'b0;
        end else if (do_act) begin
            st_d.open = 1'b1;
            st_d.row  = row_in;
            st_d.pend = 1'b0;
            st_d.cnt  = '0;
        end else if (do_rw) begin
            st_d.pend = auto_pre;
            st_d.cnt  = (burst_len == '0) ? '0 : (burst_len - ONE);
        end else if (st_q.pend) begin
            if (st_q.cnt == '0) begin
                st_d.open = 1'b0;
                st_d.pend = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = st_q.open;
    assign row_o  = st_q.row;

    AST_ACT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (do_act && !do_pre) |=> (open_o && row_o == $past(row_in))); // R2
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        do_pre |=> !open_o); // R5
    AST_AP_HOLDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && st_q.cnt != '0 && !do_pre && !do_act && !do_rw) |=> open_o); // R6
endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
    import sbm_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    parameter  int ROW_W     = 13,
    parameter  int BL_W      = 4,
    parameter  int TRC_CYC   = 7,
    localparam int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic                       a10,
    input  logic [ROW_W-1:0]           row_addr,
    input  logic [BL_W-1:0]            burst_len,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_row,
    output logic                       err_valid,
    output logic [2:0]                 err_code
);
    typedef struct packed {
        logic     valid;
        sbm_vio_e code;
    } err_t;

    sbm_cmd_e cmd;
    sbm_vio_e vio;
    logic     ref_busy;
    logic     cmd_ok;
    logic     sel_open;
    logic     any_open;
    logic     is_rw;
    err_t     err_d, err_q;

    sbm_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign sel_open = bank_open[ba];
    assign any_open = |bank_open;
    assign is_rw    = (cmd == CMD_READ) || (cmd == CMD_WRITE);

    always_comb begin
        vio = VIO_NONE;
        if (cmd != CMD_INHIBIT && cmd != CMD_NOP && ref_busy) begin
            vio = VIO_REF_WINDOW;
        end else if (cmd == CMD_MODE && any_open) begin
            vio = VIO_MODE_OPEN;
        end else if (cmd == CMD_REFRESH && any_open) begin
            vio = VIO_REF_OPEN;
        end else if (cmd == CMD_ACTIVE && sel_open) begin
            vio = VIO_ACT_OPEN;
        end else if (is_rw && !sel_open) begin
            vio = VIO_ACCESS_IDLE;
        end
    end

    assign cmd_ok = (vio == VIO_NONE);

    sbm_refresh_timer #(.TRC_CYC(TRC_CYC)) u_trc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd == CMD_REFRESH && cmd_ok),
        .busy  (ref_busy)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(b));

        sbm_bank_tracker #(.ROW_W(ROW_W), .BL_W(BL_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .do_act    (cmd == CMD_ACTIVE && cmd_ok && hit),
            .do_pre    (cmd == CMD_PRECHG && cmd_ok && (a10 || hit)),
            .do_rw     (is_rw && cmd_ok && hit),
            .auto_pre  (a10),
            .row_in    (row_addr),
            .burst_len (burst_len),
            .open_o    (bank_open[b]),
            .row_o     (open_row[b*ROW_W +: ROW_W])
        );
    end

    always_comb begin
        err_d.valid = !cmd_ok;
        err_d.code  = vio;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err_valid = err_q.valid;
    assign err_code  = err_q.code;

    AST_IDLE_ACCESS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && !bank_open[ba] && !ref_busy) |=> (err_valid && err_code == 3'd1)); // R4
    AST_MODE_OPEN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MODE && (|bank_open) && !ref_busy) |=> (err_valid && err_code == 3'd3)); // R7
    AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRECHG && a10 && !ref_busy) |=> (bank_open == '0)); // R5
    AST_WINDOW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_busy && cmd != CMD_NOP && cmd != CMD_INHIBIT) |=> (err_code == 3'd5)); // R9
endmodule

// File: tb/sdram_bank_monitor_tb.sv
module sdram_bank_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TRC        = 7;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic        a10;
    logic [12:0] row_addr;
    logic [3:0]  burst_len;
    logic [3:0]  bank_open;
    logic [51:0] open_row;
    logic        err_valid;
    logic [2:0]  err_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_bank_monitor #(.TRC_CYC(TRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .row_addr(row_addr),
        .burst_len(burst_len), .bank_open(bank_open), .open_row(open_row),
        .err_valid(err_valid), .err_code(err_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one command before an edge, return just after that edge
    task automatic issue(input logic c, input logic r, input logic k, input logic w,
                         input logic [1:0] b, input logic a, input logic [12:0] row);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = k; we_n = w; ba = b; a10 = a; row_addr = row;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();                           issue(0,1,1,1,2'd0,0,13'd0); endtask
    task automatic inhibit();                       issue(1,0,1,1,2'd1,0,13'h0AA); endtask
    task automatic act(input logic [1:0] b, input logic [12:0] r); issue(0,0,1,1,b,0,r); endtask
    task automatic rd(input logic [1:0] b, input logic ap);  issue(0,1,0,1,b,ap,13'd0); endtask
    task automatic wr(input logic [1:0] b, input logic ap);  issue(0,1,0,0,b,ap,13'd0); endtask
    task automatic pre(input logic [1:0] b, input logic all); issue(0,0,1,0,b,all,13'd0); endtask
    task automatic mode();                          issue(0,0,0,0,2'd0,0,13'd0); endtask
    task automatic refresh();                       issue(0,0,0,1,2'd0,0,13'd0); endtask

    function automatic int row_of(input int b);
        return int'(open_row[b*13 +: 13]);
    endfunction

    task automatic t_reset();
        chk("R11 bank_open", int'(bank_open), 0);
        chk("R11 err_valid", int'(err_valid), 0);
    endtask

    task automatic t_idle_bus();
        inhibit();
        chk("R1 inhibit no error", int'(err_valid), 0);
        chk("R1 inhibit no open", int'(bank_open), 0);
        nop();
        chk("R1 nop no error", int'(err_valid), 0);
    endtask

    task automatic t_activate();
        act(2'd1, 13'h1ABC);
        chk("R2 open flag", int'(bank_open), 4'b0010);
        chk("R2 row", row_of(1), 13'h1ABC);
        chk("R2 no error", int'(err_valid), 0);
        act(2'd1, 13'h0123);
        chk("R3 code", int'(err_valid) * 8 + int'(err_code), 8 + 2);
        chk("R3 R10 row kept", row_of(1), 13'h1ABC);
        nop();
        chk("R10 single pulse", int'(err_valid), 0);
    endtask

    task automatic t_access();
        rd(2'd2, 1'b0);
        chk("R4 read idle", int'(err_valid) * 8 + int'(err_code), 8 + 1);
        wr(2'd0, 1'b0);
        chk("R4 write idle", int'(err_valid) * 8 + int'(err_code), 8 + 1);
        wr(2'd1, 1'b0);
        chk("R6 write open no error", int'(err_valid), 0);
        nop(); nop();
        chk("R6 no autopre stays open", int'(bank_open), 4'b0010);
    endtask

    task automatic t_precharge();
        act(2'd3, 13'd5);
        pre(2'd3, 1'b0);
        chk("R5 single bank", int'(bank_open), 4'b0010);
        act(2'd0, 13'd7);
        chk("R2 second bank", int'(bank_open), 4'b0011);
        pre(2'd2, 1'b1);
        chk("R5 all banks", int'(bank_open), 0);
    endtask

    task automatic t_mode();
        act(2'd0, 13'd9);
        mode();
        chk("R7 code", int'(err_valid) * 8 + int'(err_code), 8 + 3);
        chk("R10 mode kept bank", int'(bank_open), 4'b0001);
        pre(2'd0, 1'b1);
        mode();
        chk("R7 idle legal", int'(err_valid), 0);
    endtask

    task automatic t_refresh_open();
        act(2'd2, 13'd3);
        refresh();
        chk("R8 code", int'(err_valid) * 8 + int'(err_code), 8 + 4);
        pre(2'd0, 1'b1);
        chk("R10 no window after flagged refresh", int'(err_valid), 0);
        chk("R5 closed", int'(bank_open), 0);
    endtask

    task automatic t_autopre();
        burst_len = 4'd4;
        act(2'd1, 13'd9);
        rd(2'd1, 1'b1);
        chk("R6 open at t", int'(bank_open), 4'b0010);
        for (int i = 1; i < 4; i++) begin
            nop();
            chk("R6 open inside burst", int'(bank_open), 4'b0010);
        end
        nop();
        chk("R6 closed at t+L", int'(bank_open), 0);
        burst_len = 4'd1;
        act(2'd3, 13'd11);
        wr(2'd3, 1'b1);
        chk("R6 L1 open at t", int'(bank_open), 4'b1000);
        nop();
        chk("R6 L1 closed at t+1", int'(bank_open), 0);
        rd(2'd3, 1'b0);
        chk("R4 access after autopre", int'(err_code), 1);
    endtask

    task automatic t_refresh_window();
        refresh();
        chk("R9 legal refresh", int'(err_valid), 0);
        rd(2'd0, 1'b0);
        chk("R10 window beats idle access", int'(err_code), 5);
        for (int i = 2; i < TRC - 1; i++) nop();
        act(2'd0, 13'd4);
        chk("R9 last busy cycle", int'(err_valid) * 8 + int'(err_code), 8 + 5);
        chk("R10 flagged act no open", int'(bank_open), 0);
        act(2'd0, 13'd4);
        chk("R9 window over", int'(err_valid), 0);
        chk("R9 act applied", int'(bank_open), 4'b0001);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        ba = '0; a10 = 1'b0; row_addr = '0; burst_len = 4'd4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_idle_bus();
        t_activate();
        t_access();
        t_precharge();
        t_mode();
        t_refresh_open();
        t_autopre();
        t_refresh_window();
        summary();
    end
endmodule